// File: doc/BRIEF.md
# Command Mailbox Write Sequencer

This block hands a command of up to 18 sixteen-bit words to a co-processor through a word-addressed mailbox. The mailbox is reached over a simple write bus with address, data, a write enable and a ready return. The co-processor starts working when the first word of the command, the command word, is written. For that reason the sequencer writes every other word before it, and the command word always goes last. After each write accepted on the bus the sequencer waits a fixed settling gap, nominally 5 ms. It does this after the final write as well.

Commands come from a one-cycle request. A request either builds a command or carries one supplied in full. The block builds two kinds of command. The first switches the 22 kHz tone on or off. The second sends a satellite-control (DiSEqC) message of up to ten bytes together with a burst selection. In raw mode the caller supplies all 18 words and a length. While a command is in flight the block reports busy. When it finishes, it pulses done for one cycle.

Top module: `cmd_mbox_seq`

## Requirements
- R1: During reset, and right after reset is released, `wr_en_o`, `busy_o` and `done_o` are low. Asserting `rst_ni` in the middle of a command drops all three at once.
- R2: For a command of length L, the words with index 2 through L-1 are written first, in ascending index order. Word k goes to address BASE_ADDR + 2*k. A command whose length is 2 or less writes none of these words.
- R3: The next write goes to BASE_ADDR + 2 and carries word 1. When L is 0 it carries zero instead. In raw mode (`req_kind_i[1]` = 1) the length is `raw_len_i` clamped to 18.
- R4: The final write of every command goes to BASE_ADDR and carries word 0.
- R5: After every accepted write, `wr_en_o` stays low for exactly GAP_CYCLES cycles. Only then is the next write presented or done raised.
- R6: A write is accepted on a clock edge where both `wr_en_o` and `wr_rdy_i` are high. Until then `wr_en_o`, `wr_addr_o` and `wr_data_o` are held steady.
- R7: `busy_o` rises in the cycle after a request is taken. `done_o` is high for exactly one cycle, GAP_CYCLES+1 cycles after the final write is accepted, and `busy_o` is low from the cycle after that.
- R8: A tone request (`req_kind_i` = 2'b00) builds a 2-word command. Word 0 is {CMD_TYPE, TONE_ON_CODE} when `tone_on_i` = 1 and {CMD_TYPE, TONE_OFF_CODE} otherwise. Word 1 is zero.
- R9: A message request (`req_kind_i` = 2'b01) builds an 18-word command. Word 0 is {CMD_TYPE, MSG_CODE}. The message length n is `msg_len_i` clamped to 10. Word 1 holds n+2 and word 2 holds n.
- R10: In a message command, word 3 holds the burst selection from `burst_i`. For 2'b10 (burst B) it is 16'h0001. For 2'b01 (burst A) it is 16'h0000. For 2'b00 or 2'b11 (no burst) it is 16'hFFFF.
- R11: Message byte i is `msg_bytes_i[8*i+7:8*i]`. It is placed zero-extended in word 4+i for each i < n. Words 4+n through 17 are zero.
- R12: A request made while `busy_o` is high has no effect. The command in flight writes exactly its own words and no further writes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle request strobe, taken when idle |
| req_kind_i | input | 2 | 00 tone, 01 message, 1x raw |
| tone_on_i | input | 1 | Tone request: 1 on, 0 off |
| msg_len_i | input | 4 | Message byte count, clamped to 10 |
| msg_bytes_i | input | 80 | Message bytes, byte i in bits 8i+7:8i |
| burst_i | input | 2 | 01 burst A, 10 burst B, else none |
| raw_len_i | input | 5 | Raw command length, clamped to 18 |
| raw_words_i | input | 288 | Raw words, word i in bits 16i+15:16i |
| busy_o | output | 1 | Command in flight |
| done_o | output | 1 | One-cycle completion pulse |
| wr_addr_o | output | ADDR_W | Mailbox write address |
| wr_data_o | output | 16 | Mailbox write data |
| wr_en_o | output | 1 | Write request, held until ready |
| wr_rdy_i | input | 1 | Bus ready; completes the write |

## Verification
The bench aims at the length edges of the ordering: lengths 0, 1 and 2, a clamped raw length of 25, and a clamped message length of 13. A design that miscounts the range would write a stray word 2, skip word 1, or write past word 17. For L = 0 it would leak stale data instead of zero to BASE_ADDR+2. Each of the four burst encodings and message lengths 0, 3, 7, 10 and 13 are checked word by word; a wrong clamp shows up as a bad word 1 or 2, or as bytes beyond the tenth. Ready stalls, a second request mid-command, and a reset mid-command show whether the block drops or repeats a held write, restarts on a stray request, or keeps driving the bus after reset. The gap is measured after every write, including the doorbell, so a design that skips the last settling wait shows up.

// File: rtl/cmd_mbox_pkg.sv
package cmd_mbox_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MAX_WORDS = 18;
  localparam int unsigned MAX_MSG   = 10;
  localparam int unsigned MSG_LEN_W = 4;
  localparam int unsigned IDX_W     = $clog2(MAX_WORDS + 1);
  localparam int unsigned MSG_BASE  = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [MAX_WORDS-1:0] cmd_words_t;

  localparam logic [1:0] KIND_TONE = 2'b00;
  localparam logic [1:0] KIND_MSG  = 2'b01;
  localparam logic [1:0] BURST_A   = 2'b01;
  localparam logic [1:0] BURST_B   = 2'b10;

  localparam word_t BURST_WORD_A    = 16'h0000;
  localparam word_t BURST_WORD_B    = 16'h0001;
  localparam word_t BURST_WORD_NONE = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_GAP, ST_DONE} seq_state_e;
endpackage

// File: rtl/mbox_cmd_build.sv
module mbox_cmd_build
  import cmd_mbox_pkg::*;
#(
  parameter logic [7:0] CMD_TYPE      = 8'h08,
  parameter logic [7:0] TONE_ON_CODE  = 8'h01,
  parameter logic [7:0] TONE_OFF_CODE = 8'h02,
  parameter logic [7:0] MSG_CODE      = 8'h03
) (
  input  logic [1:0]                   kind_i,
  input  logic                         tone_on_i,
  input  logic [MSG_LEN_W-1:0]         msg_len_i,
  input  logic [MAX_MSG*BYTE_W-1:0]    msg_bytes_i,
  input  logic [1:0]                   burst_i,
  input  logic [IDX_W-1:0]             raw_len_i,
  input  logic [MAX_WORDS*WORD_W-1:0]  raw_words_i,
  output cmd_words_t                   words_o,
  output logic [IDX_W-1:0]             len_o
);
  localparam int unsigned TONE_LEN = 2;

  cmd_words_t raw_w;
  word_t      msg_w [MAX_MSG];
  logic [MSG_LEN_W-1:0] msg_n;

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_raw
    assign raw_w[g] = raw_words_i[g*WORD_W +: WORD_W];
  end

  for (genvar g = 0; g < MAX_MSG; g++) begin : g_msg
    assign msg_w[g] = (MSG_LEN_W'(g) < msg_n) ? WORD_W'(msg_bytes_i[g*BYTE_W +: BYTE_W]) : '0;
  end

  assign msg_n = (msg_len_i > MSG_LEN_W'(MAX_MSG)) ? MSG_LEN_W'(MAX_MSG) : msg_len_i;

  always_comb begin
    words_o = '0;
    len_o   = '0;
    if (kind_i[1]) begin
      len_o = (raw_len_i > IDX_W'(MAX_WORDS)) ? IDX_W'(MAX_WORDS) : raw_len_i;
      for (int i = 0; i < MAX_WORDS; i++)
        if (IDX_W'(i) < len_o) words_o[i] = raw_w[i];
    end else if (kind_i == KIND_TONE) begin
      len_o      = IDX_W'(TONE_LEN);
      words_o[0] = {CMD_TYPE, tone_on_i ? TONE_ON_CODE : TONE_OFF_CODE};
    end else begin
      len_o      = IDX_W'(MAX_WORDS);
      words_o[0] = {CMD_TYPE, MSG_CODE};
      words_o[1] = WORD_W'(msg_n) + WORD_W'(2);
      words_o[2] = WORD_W'(msg_n);
      unique case (burst_i)
        BURST_A: words_o[3] = BURST_WORD_A;
        BURST_B: words_o[3] = BURST_WORD_B;
        default: words_o[3] = BURST_WORD_NONE;
      endcase
      for (int i = 0; i < MAX_MSG; i++) words_o[MSG_BASE + i] = msg_w[i];
    end
  end
endmodule

// File: rtl/mbox_gap_timer.sv
module mbox_gap_timer #(
  parameter int unsigned GAP_CYCLES = 625_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= CNT_W'(GAP_CYCLES - 1);
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign expire_o = active_q && (cnt_q == '0);

  // R5
  gap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
endmodule

// File: rtl/mbox_wr_seq.sv
module mbox_wr_seq
  import cmd_mbox_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_words_t        words_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic              wr_rdy_i,
  input  logic              gap_active_i,
  input  logic              gap_expire_i,
  output logic              gap_start_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output word_t             wr_data_o,
  output logic              wr_en_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e       state_q;
  cmd_words_t       words_q;
  logic [IDX_W-1:0] len_q, idx_q, idx_next;
  logic             fin_q;

  always_comb begin
    if (idx_q >= IDX_W'(2))
      idx_next = ((idx_q + IDX_W'(1)) < len_q) ? idx_q + IDX_W'(1) : IDX_W'(1);
    else
      idx_next = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      words_q <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          words_q <= words_i;
          len_q   <= len_i;
          idx_q   <= (len_i > IDX_W'(2)) ? IDX_W'(2) : IDX_W'(1);
          fin_q   <= 1'b0;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (wr_rdy_i) begin
          // word 0 is the doorbell and ends the command
          if (idx_q == '0) fin_q <= 1'b1;
          else             idx_q <= idx_next;
          state_q <= ST_GAP;
        end
        ST_GAP: if (gap_expire_i) state_q <= fin_q ? ST_DONE : ST_WRITE;
        ST_DONE: begin
          fin_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o     = (state_q == ST_WRITE);
  assign gap_start_o = wr_en_o && wr_rdy_i;
  assign wr_addr_o   = BASE_ADDR + ADDR_W'({idx_q, 1'b0});
  assign wr_data_o   = (idx_q == IDX_W'(1) && len_q == '0) ? '0 : words_q[idx_q];
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  // R6
  hold_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_rdy_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  // R5
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_active_i |-> !wr_en_o);
  // R4
  doorbell_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_rdy_i && wr_addr_o == BASE_ADDR) |=> (gap_active_i && !done_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R2
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o < BASE_ADDR + ADDR_W'(2 * MAX_WORDS)));
endmodule

// File: rtl/cmd_mbox_seq.sv
module cmd_mbox_seq
  import cmd_mbox_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR     = 16'h0400,
  parameter int unsigned       GAP_CYCLES    = 625_000,
  parameter logic [7:0]        CMD_TYPE      = 8'h08,
  parameter logic [7:0]        TONE_ON_CODE  = 8'h01,
  parameter logic [7:0]        TONE_OFF_CODE = 8'h02,
  parameter logic [7:0]        MSG_CODE      = 8'h03
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [1:0]                  req_kind_i,
  input  logic                        tone_on_i,
  input  logic [MSG_LEN_W-1:0]        msg_len_i,
  input  logic [MAX_MSG*BYTE_W-1:0]   msg_bytes_i,
  input  logic [1:0]                  burst_i,
  input  logic [IDX_W-1:0]            raw_len_i,
  input  logic [MAX_WORDS*WORD_W-1:0] raw_words_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [ADDR_W-1:0]           wr_addr_o,
  output logic [WORD_W-1:0]           wr_data_o,
  output logic                        wr_en_o,
  input  logic                        wr_rdy_i
);
  cmd_words_t       built_words;
  logic [IDX_W-1:0] built_len;
  logic             gap_start, gap_active, gap_expire, start;

  // requests while busy are dropped
  assign start = req_valid_i && !busy_o;

  mbox_cmd_build #(
    .CMD_TYPE(CMD_TYPE), .TONE_ON_CODE(TONE_ON_CODE),
    .TONE_OFF_CODE(TONE_OFF_CODE), .MSG_CODE(MSG_CODE)
  ) u_build (
    .kind_i(req_kind_i), .tone_on_i(tone_on_i), .msg_len_i(msg_len_i),
    .msg_bytes_i(msg_bytes_i), .burst_i(burst_i), .raw_len_i(raw_len_i),
    .raw_words_i(raw_words_i), .words_o(built_words), .len_o(built_len)
  );

  mbox_wr_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .words_i(built_words),
    .len_i(built_len), .wr_rdy_i(wr_rdy_i), .gap_active_i(gap_active),
    .gap_expire_i(gap_expire), .gap_start_o(gap_start), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_en_o(wr_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  mbox_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(gap_start),
    .active_o(gap_active), .expire_o(gap_expire)
  );

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/sim_cmd_mbox_seq.sv
`timescale 1ns/1ps
module sim_cmd_mbox_seq;
  localparam int          GAP  = 4;
  localparam logic [15:0] BASE = 16'h0200;
  localparam logic [7:0]  CTYP = 8'h08, TON = 8'h01, TOFF = 8'h02, SUB = 8'h03;

  typedef struct packed {
    logic [1:0] kind; logic ton; logic [3:0] mlen; logic [1:0] burst;
    logic [4:0] rlen; logic [7:0] seed; logic stall; logic busyreq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 4'd0,  2'd0, 5'd0,  8'h11, 1'b0, 1'b0},
    '{2'd0, 1'b0, 4'd0,  2'd0, 5'd0,  8'h12, 1'b1, 1'b0},
    '{2'd1, 1'b0, 4'd3,  2'd1, 5'd0,  8'h21, 1'b0, 1'b0},
    '{2'd1, 1'b0, 4'd10, 2'd2, 5'd0,  8'h33, 1'b1, 1'b0},
    '{2'd1, 1'b0, 4'd13, 2'd0, 5'd0,  8'h45, 1'b0, 1'b0},
    '{2'd1, 1'b0, 4'd0,  2'd3, 5'd0,  8'h57, 1'b0, 1'b0},
    '{2'd2, 1'b0, 4'd0,  2'd0, 5'd5,  8'h61, 1'b0, 1'b0},
    '{2'd2, 1'b0, 4'd0,  2'd0, 5'd0,  8'h72, 1'b0, 1'b0},
    '{2'd3, 1'b0, 4'd0,  2'd0, 5'd1,  8'h83, 1'b1, 1'b0},
    '{2'd2, 1'b0, 4'd0,  2'd0, 5'd25, 8'h94, 1'b1, 1'b0},
    '{2'd0, 1'b1, 4'd0,  2'd0, 5'd0,  8'hA5, 1'b0, 1'b1},
    '{2'd1, 1'b0, 4'd7,  2'd2, 5'd0,  8'hB6, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, tone_on = 1'b0, wr_rdy = 1'b1;
  logic [1:0] req_kind = '0, burst = '0;
  logic [3:0] msg_len = '0;
  logic [79:0] msg_bytes = '0;
  logic [4:0] raw_len = '0;
  logic [287:0] raw_words = '0;
  logic busy, done, wr_en;
  logic [15:0] wr_addr, wr_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic stall_en = 1'b0;

  // monitor state
  logic [15:0] got_addr [64], got_data [64];
  int gaps [64];
  int nwr = 0, ngap = 0, done_cnt = 0, done_run = 0, done_wide = 0, hold_err = 0, gap_n = 0;
  logic in_gap = 1'b0, hold_pend = 1'b0;
  logic [15:0] hold_a, hold_d;

  // expected model
  logic [15:0] exp_addr [64], exp_data [64];
  int exp_idx [64];
  int exp_n = 0;

  cmd_mbox_seq #(.ADDR_W(16), .BASE_ADDR(BASE), .GAP_CYCLES(GAP), .CMD_TYPE(CTYP),
    .TONE_ON_CODE(TON), .TONE_OFF_CODE(TOFF), .MSG_CODE(SUB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .tone_on_i(tone_on), .msg_len_i(msg_len), .msg_bytes_i(msg_bytes), .burst_i(burst),
    .raw_len_i(raw_len), .raw_words_i(raw_words), .busy_o(busy), .done_o(done),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_en_o(wr_en), .wr_rdy_i(wr_rdy));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    wr_rdy <= stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend && !(wr_en && wr_addr == hold_a && wr_data == hold_d)) hold_err++;
      hold_pend = wr_en && !wr_rdy;
      hold_a = wr_addr; hold_d = wr_data;
      if (in_gap && (wr_en || done)) begin
        gaps[ngap] = gap_n; ngap++; in_gap = 1'b0;
      end
      if (wr_en && wr_rdy) begin
        got_addr[nwr] = wr_addr; got_data[nwr] = wr_data; nwr++;
        in_gap = 1'b1; gap_n = 0;
      end else if (in_gap) gap_n++;
      if (done) begin
        done_cnt++; done_run++;
        if (done_run > 1) done_wide++;
      end else done_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  function automatic logic [15:0] raw_of(input logic [7:0] seed, input int i);
    return {seed, 8'(i)} ^ 16'h5A00;
  endfunction

  task automatic drive(input vec_t v);
    req_kind = v.kind; tone_on = v.ton; msg_len = v.mlen; burst = v.burst; raw_len = v.rlen;
    for (int i = 0; i < 10; i++) msg_bytes[i*8 +: 8] = byte_of(v.seed, i);
    for (int i = 0; i < 18; i++) raw_words[i*16 +: 16] = raw_of(v.seed, i);
  endtask

  task automatic build_exp(input vec_t v);
    logic [15:0] w [18];
    int len, n;
    for (int i = 0; i < 18; i++) w[i] = '0;
    if (v.kind[1]) begin
      len = (v.rlen > 18) ? 18 : int'(v.rlen);
      for (int i = 0; i < len; i++) w[i] = raw_of(v.seed, i);
    end else if (v.kind == 2'b00) begin
      len = 2; w[0] = {CTYP, v.ton ? TON : TOFF};
    end else begin
      len = 18; n = (v.mlen > 10) ? 10 : int'(v.mlen);
      w[0] = {CTYP, SUB}; w[1] = 16'(n + 2); w[2] = 16'(n);
      w[3] = (v.burst == 2'b01) ? 16'h0000 : (v.burst == 2'b10) ? 16'h0001 : 16'hFFFF;
      for (int i = 0; i < n; i++) w[4+i] = {8'h00, byte_of(v.seed, i)};
    end
    exp_n = 0;
    for (int i = 2; i < len; i++) begin
      exp_idx[exp_n] = i; exp_addr[exp_n] = BASE + 16'(2*i); exp_data[exp_n] = w[i]; exp_n++;
    end
    exp_idx[exp_n] = 1; exp_addr[exp_n] = BASE + 16'd2;
    exp_data[exp_n] = (len == 0) ? 16'h0 : w[1]; exp_n++;
    exp_idx[exp_n] = 0; exp_addr[exp_n] = BASE; exp_data[exp_n] = w[0]; exp_n++;
  endtask

  function automatic string tag_of(input logic [1:0] kind, input int idx);
    if (kind == 2'b00) return "R8";
    if (kind == 2'b01) begin
      if (idx == 0 || idx == 1 || idx == 2) return "R9";
      if (idx == 3) return "R10";
      return "R11";
    end
    if (idx == 0) return "R4";
    if (idx == 1) return "R3";
    return "R2";
  endfunction

  task automatic clear_mon();
    nwr = 0; ngap = 0; done_cnt = 0; done_run = 0; done_wide = 0; hold_err = 0;
    in_gap = 1'b0; hold_pend = 1'b0;
  endtask

  task automatic run(input vec_t v);
    int t;
    vec_t other;
    build_exp(v);
    @(posedge clk); #2;
    clear_mon();
    stall_en = v.stall;
    drive(v); req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    check(busy === 1'b1, "R7", "busy after request", int'(busy), 1);
    if (v.busyreq) begin
      t = 0;
      while (nwr < 1 && t < 500) begin @(posedge clk); #2; t++; end
      other = v; other.kind = 2'b10; other.rlen = 5'd3; other.seed = ~v.seed;
      drive(other); req_valid = 1'b1;
      @(posedge clk); #2;
      req_valid = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 3000) begin @(posedge clk); #2; t++; end
    check(done_cnt > 0, "R7", "done seen", done_cnt, 1);
    repeat (3*GAP + 6) @(posedge clk);
    #2;
    check(nwr == exp_n, v.busyreq ? "R12" : "R2", "write count", nwr, exp_n);
    for (int k = 0; k < exp_n && k < nwr; k++) begin
      check(got_addr[k] == exp_addr[k], (exp_idx[k] >= 2) ? "R2" : (exp_idx[k] == 1) ? "R3" : "R4",
            $sformatf("addr of write %0d", k), int'(got_addr[k]), int'(exp_addr[k]));
      check(got_data[k] == exp_data[k], tag_of(v.kind, exp_idx[k]),
            $sformatf("data of word %0d", exp_idx[k]), int'(got_data[k]), int'(exp_data[k]));
    end
    check(ngap == nwr, "R5", "gap count", ngap, nwr);
    for (int k = 0; k < ngap; k++)
      check(gaps[k] == GAP, "R5", $sformatf("gap after write %0d", k), gaps[k], GAP);
    check(done_cnt == 1 && done_wide == 0, "R7", "done pulses", done_cnt, 1);
    check(busy === 1'b0, "R7", "busy after done", int'(busy), 0);
    check(hold_err == 0, "R6", "held write changed", hold_err, 0);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(wr_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs in reset",
          int'({wr_en, busy, done}), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(wr_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs after reset",
          int'({wr_en, busy, done}), 0);

    for (int i = 0; i < NV; i++) run(VECS[i]);

    // R1: reset in the middle of a message command
    @(posedge clk); #2;
    clear_mon();
    drive(VECS[3]); req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (nwr < 3) begin @(posedge clk); #2; end
    rst_n = 1'b0;
    #1;
    check(wr_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs on mid-run reset",
          int'({wr_en, busy, done}), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (2*GAP) @(posedge clk);
    #2;
    check(busy === 1'b0 && wr_en === 1'b0, "R1", "idle after mid-run reset", int'({busy, wr_en}), 0);
    run(VECS[0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule